// File: doc/BRIEF.md
# Carry-Centric 8-Bit ALU with Flag Write Mask

This block is the combinational arithmetic and logic unit for a small 8-bit accumulator core whose flag rules give the carry flag more uses than usual. One operation code, two operands and the incoming carry, zero, negative and overflow flags go in. The block returns the result byte, the merged flag set and a per-flag write mask. A flag the operation does not define keeps its incoming value in the merged set, and its mask bit is low.

The operations fall into four families. Addition and subtraction come with and without the carry; subtraction uses the no-borrow convention. The bitwise operations load carry, negative and overflow from result bits. Negate, compare, increment and decrement set carry from the result. Carry-conditional memory increment and decrement and the two rotates through carry make up the rest. All arithmetic shares one adder, so every operation in that group is an operand selection. Only the rotates need a second path.

Top module: `calu_top`

## Requirements
- R1: Op code 0 (plain add) yields A+B with the incoming carry ignored. Op code 1 yields A+B+C. Both write C (carry out of bit 7), Z, N and V, where V is signed two's-complement overflow.
- R2: Op code 2 (plain subtract) yields A-B. Op code 3 yields A-B-(1-C). Both write C=1 when no borrow occurred, together with Z, N and V (signed overflow of the subtraction).
- R3: Op codes 4 (XOR), 5 (OR) and 6 (AND) combine A with B, and op code 7 inverts A. Each writes N = result bit 7, V = result bit 6 and C = result bit 0, and leaves Z unchanged.
- R4: Op code 8 (negate) yields 0-B and writes Z and N, with C = 1 exactly when the result is non-zero. V is unchanged.
- R5: Op code 9 (compare) returns A unchanged as the result. It writes Z and N from A-B and sets C to the inverse of that Z. V is unchanged.
- R6: Op code 10 yields A+1, with C set only on the wrap from 0xFF to 0x00. Op code 11 yields A-1, with C cleared only on the wrap from 0x00 to 0xFF. Both write Z and N and leave V unchanged.
- R7: Op code 12 yields A+C, with C set on the wrap past 0xFF. Op code 13 yields A-(1-C), with C cleared only on a borrow. Both write Z and N and leave V unchanged.
- R8: Op code 14 rotates right: C goes into bit 7 and bit 0 becomes the new C. Op code 15 rotates left: C goes into bit 0 and bit 7 becomes the new C. Both write Z and N and leave V unchanged.
- R9: Op codes 16 to 31 pass B to the result, write no flag (mask 0) and return the incoming flags unchanged.
- R10: The flag vectors use bit 0 = C, bit 1 = Z, bit 2 = N and bit 3 = V. A mask bit is 1 exactly for the flags the operation defines, and every flag with a mask bit of 0 appears in the output equal to its input.
- R11: Wherever Z and N are written from the output result, Z is 1 exactly when the result is 0x00 and N equals result bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code (see requirements) |
| opa | input | 8 | First operand (accumulator side) |
| opb | input | 8 | Second operand (memory or immediate side) |
| flags_in | input | 4 | Incoming flags {V,N,Z,C} |
| result | output | 8 | Result byte |
| flags_out | output | 4 | Flags after the operation, unaffected bits passed through |
| flag_wr | output | 4 | Per-flag write mask {V,N,Z,C} |

## Verification
Every result is combinational, so it is due in the same cycle that its inputs are applied, with no register in between. The bench drives a new operation, operand pair and flag set just after each rising edge. It compares the result, merged flags and mask against a behavioural integer model at the following falling edge, once the logic has settled and before the next inputs arrive. Stimulus covers every op code crossed with the boundary operands 0x00, 0x01, 0x7F, 0x80, 0xFE and 0xFF and all sixteen flag combinations, followed by pseudo-random vectors.

// File: rtl/calu_pkg.sv
package calu_pkg;
  localparam int NFLAG = 4;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_XOR  = 5'd4,  OP_OR   = 5'd5,  OP_AND  = 5'd6,  OP_NOT  = 5'd7,
    OP_NEG  = 5'd8,  OP_CMP  = 5'd9,  OP_INC  = 5'd10, OP_DEC  = 5'd11,
    OP_CINC = 5'd12, OP_CDEC = 5'd13, OP_ROR  = 5'd14, OP_ROL  = 5'd15,
    OP_PASS = 5'd16
  } calu_op_e;

  localparam logic [NFLAG-1:0] MASK_ALL  = 4'b1111;
  localparam logic [NFLAG-1:0] MASK_CNV  = 4'b1101;
  localparam logic [NFLAG-1:0] MASK_CZN  = 4'b0111;
  localparam logic [NFLAG-1:0] MASK_NONE = 4'b0000;
endpackage

// File: rtl/calu_adder.sv
module calu_adder #(
  parameter int W = 8
) (
  input  calu_pkg::calu_op_e op,
  input  logic [W-1:0]       opa,
  input  logic [W-1:0]       opb,
  input  logic               cin,
  output logic [W-1:0]       sum,
  output logic               cout,
  output logic               ovf
);
  import calu_pkg::*;

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONES = '1;

  function automatic logic [W:0] add_full(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  function automatic logic signed_ovf(input logic xs, input logic ys, input logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

  logic [W-1:0] x_sel, y_sel;
  logic         c_sel;
  logic [W:0]   full;

  always_comb begin
    x_sel = opa;
    y_sel = opb;
    c_sel = 1'b0;
    unique case (op)
      OP_ADD:  begin y_sel = opb;  c_sel = 1'b0; end
      OP_ADC:  begin y_sel = opb;  c_sel = cin;  end
      OP_SUB:  begin y_sel = ~opb; c_sel = 1'b1; end
      OP_SBC:  begin y_sel = ~opb; c_sel = cin;  end
      OP_NEG:  begin x_sel = ZERO; y_sel = ~opb; c_sel = 1'b1; end
      OP_CMP:  begin y_sel = ~opb; c_sel = 1'b1; end
      OP_INC:  begin y_sel = ZERO; c_sel = 1'b1; end
      OP_DEC:  begin y_sel = ONES; c_sel = 1'b0; end
      OP_CINC: begin y_sel = ZERO; c_sel = cin;  end
      OP_CDEC: begin y_sel = ONES; c_sel = cin;  end
      default: begin x_sel = opa;  y_sel = opb;  c_sel = 1'b0; end
    endcase
  end

  assign full = add_full(x_sel, y_sel, c_sel);
  assign sum  = full[W-1:0];
  assign cout = full[W];
  assign ovf  = signed_ovf(x_sel[W-1], y_sel[W-1], full[W-1]);

  always_comb begin
    if (op == OP_INC) assert_inc_wrap_R6: assert (cout == (opa == ONES))
      else $error("increment carry does not match wrap");
    if (op == OP_DEC) assert_dec_wrap_R6: assert (cout == (opa != ZERO))
      else $error("decrement carry does not match wrap");
  end
endmodule

// File: rtl/calu_bitops.sv
module calu_bitops #(
  parameter int W = 8
) (
  input  calu_pkg::calu_op_e op,
  input  logic [W-1:0]       opa,
  input  logic [W-1:0]       opb,
  input  logic               cin,
  output logic [W-1:0]       res,
  output logic               rot_cout
);
  import calu_pkg::*;

  always_comb begin
    res      = opa;
    rot_cout = cin;
    unique case (op)
      OP_XOR: res = opa ^ opb;
      OP_OR:  res = opa | opb;
      OP_AND: res = opa & opb;
      OP_NOT: res = ~opa;
      OP_ROR: begin res = {cin, opa[W-1:1]}; rot_cout = opa[0];   end
      OP_ROL: begin res = {opa[W-2:0], cin}; rot_cout = opa[W-1]; end
      default: begin res = opa; rot_cout = cin; end
    endcase
  end

  always_comb begin
    if (op == OP_ROR) assert_ror_in_R8: assert (res[W-1] == cin && rot_cout == opa[0])
      else $error("rotate right carry path wrong");
    if (op == OP_ROL) assert_rol_in_R8: assert (res[0] == cin && rot_cout == opa[W-1])
      else $error("rotate left carry path wrong");
  end
endmodule

// File: rtl/calu_flagmerge.sv
module calu_flagmerge #(
  parameter int NF = 4
) (
  input  logic [NF-1:0] flags_old,
  input  logic [NF-1:0] flags_new,
  input  logic [NF-1:0] wr_mask,
  output logic [NF-1:0] flags_merged
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    assign flags_merged[i] = wr_mask[i] ? flags_new[i] : flags_old[i];
  end
endmodule

// File: rtl/calu_top.sv
module calu_top #(
  parameter int DATA_W = 8
) (
  input  logic [4:0]        op_sel,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [3:0]        flags_in,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flags_out,
  output logic [3:0]        flag_wr
);
  import calu_pkg::*;

  localparam int MSB = DATA_W - 1;

  calu_op_e          op;
  logic [DATA_W-1:0] add_sum, bit_res;
  logic              add_cout, add_ovf, rot_cout;
  logic [NFLAG-1:0]  flags_new;

  assign op = (op_sel > 5'd15) ? OP_PASS : calu_op_e'(op_sel);

  calu_adder #(.W(DATA_W)) i_adder (
    .op(op), .opa(opa), .opb(opb), .cin(flags_in[FC]),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
  );

  calu_bitops #(.W(DATA_W)) i_bitops (
    .op(op), .opa(opa), .opb(opb), .cin(flags_in[FC]),
    .res(bit_res), .rot_cout(rot_cout)
  );

  always_comb begin
    result    = opb;
    flags_new = '0;
    flag_wr   = MASK_NONE;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        result        = add_sum;
        flags_new[FC] = add_cout;
        flags_new[FZ] = (add_sum == '0);
        flags_new[FN] = add_sum[MSB];
        flags_new[FV] = add_ovf;
        flag_wr       = MASK_ALL;
      end
      OP_XOR, OP_OR, OP_AND, OP_NOT: begin
        result        = bit_res;
        flags_new[FC] = bit_res[0];
        flags_new[FN] = bit_res[MSB];
        flags_new[FV] = bit_res[MSB-1];
        flag_wr       = MASK_CNV;
      end
      OP_NEG, OP_CMP: begin
        result        = (op == OP_CMP) ? opa : add_sum;
        flags_new[FZ] = (add_sum == '0);
        flags_new[FN] = add_sum[MSB];
        flags_new[FC] = (add_sum != '0);
        flag_wr       = MASK_CZN;
      end
      OP_INC, OP_DEC, OP_CINC, OP_CDEC: begin
        result        = add_sum;
        flags_new[FC] = add_cout;
        flags_new[FZ] = (add_sum == '0);
        flags_new[FN] = add_sum[MSB];
        flag_wr       = MASK_CZN;
      end
      OP_ROR, OP_ROL: begin
        result        = bit_res;
        flags_new[FC] = rot_cout;
        flags_new[FZ] = (bit_res == '0);
        flags_new[FN] = bit_res[MSB];
        flag_wr       = MASK_CZN;
      end
      default: begin
        result  = opb;
        flag_wr = MASK_NONE;
      end
    endcase
  end

  calu_flagmerge #(.NF(NFLAG)) i_merge (
    .flags_old(flags_in), .flags_new(flags_new),
    .wr_mask(flag_wr), .flags_merged(flags_out)
  );

  always_comb begin
    if (op_sel > 5'd15) assert_pass_quiet_R9: assert (flag_wr == '0 && flags_out == flags_in && result == opb)
      else $error("pass op touched flags or result");
    if (op == OP_CMP) assert_cmp_keeps_a_R5: assert (result == opa && flags_out[FC] != flags_out[FZ])
      else $error("compare changed result or carry not inverse of zero");
    if (op == OP_XOR || op == OP_OR || op == OP_AND || op == OP_NOT)
      assert_logic_z_kept_R3: assert (flags_out[FZ] == flags_in[FZ] && flags_out[FC] == result[0])
        else $error("logic op disturbed zero or carry not bit 0");
    if (op == OP_NEG) assert_neg_carry_R4: assert (flags_out[FC] == (opb != '0) && flags_out[FV] == flags_in[FV])
      else $error("negate carry or overflow wrong");
    if (flag_wr[FZ] && op != OP_CMP) assert_zero_flag_R11: assert (flags_out[FZ] == (result == '0))
      else $error("zero flag disagrees with result");
  end
endmodule

// File: tb/test_calu_top.sv
module test_calu_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op_sel = '0;
  logic [7:0] opa = '0, opb = '0;
  logic [3:0] flags_in = '0;
  logic [7:0] result;
  logic [3:0] flags_out, flag_wr;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  calu_top i_calu_top (
    .op_sel(op_sel), .opa(opa), .opb(opb), .flags_in(flags_in),
    .result(result), .flags_out(flags_out), .flag_wr(flag_wr)
  );

  function automatic string req_of(int op);
    if (op <= 1) return "R1";
    if (op <= 3) return "R2";
    if (op <= 7) return "R3";
    if (op == 8) return "R4";
    if (op == 9) return "R5";
    if (op <= 11) return "R6";
    if (op <= 13) return "R7";
    if (op <= 15) return "R8";
    return "R9";
  endfunction

  // behavioural model: flags packed C=bit0 Z=bit1 N=bit2 V=bit3 (R10)
  task automatic model(input int op, input int a, input int b, input int f,
                       output int r, output int fo, output int m);
    int c, s, sa, sb, sr, fl_c, fl_z, fl_n, fl_v;
    c  = f & 1;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    fl_c = 0; fl_z = 0; fl_n = 0; fl_v = 0; m = 0; r = b;
    case (op)
      0, 1: begin
        s = a + b + ((op == 1) ? c : 0); sr = sa + sb + ((op == 1) ? c : 0);
        r = s & 255; fl_c = (s > 255); fl_v = (sr > 127 || sr < -128); m = 15;
      end
      2, 3: begin
        s = a - b - ((op == 3) ? 1 - c : 0); sr = sa - sb - ((op == 3) ? 1 - c : 0);
        r = s & 255; fl_c = (s >= 0); fl_v = (sr > 127 || sr < -128); m = 15;
      end
      4, 5, 6, 7: begin
        r = (op == 4) ? (a ^ b) : (op == 5) ? (a | b) : (op == 6) ? (a & b) : (255 - a);
        fl_c = r & 1; fl_v = (r >> 6) & 1; m = 13;
      end
      8:  begin r = (256 - b) & 255; fl_c = (r != 0); m = 7; end
      9:  begin s = (a - b) & 255; r = a; fl_c = (s != 0); m = 7; end
      10: begin r = (a + 1) & 255; fl_c = (a == 255); m = 7; end
      11: begin r = (a + 255) & 255; fl_c = (a != 0); m = 7; end
      12: begin s = a + c; r = s & 255; fl_c = (s > 255); m = 7; end
      13: begin s = a - (1 - c); r = s & 255; fl_c = (s >= 0); m = 7; end
      14: begin r = (c << 7) | (a >> 1); fl_c = a & 1; m = 7; end
      15: begin r = ((a << 1) & 255) | c; fl_c = a >> 7; m = 7; end
      default: begin r = b; m = 0; end
    endcase
    if (op == 9) begin fl_z = ((a - b) & 255) == 0; fl_n = (((a - b) & 255) >> 7); end
    else begin fl_z = (r == 0); fl_n = r >> 7; end
    fo = (f & ~m) | (m & (fl_c | (fl_z << 1) | (fl_n << 2) | (fl_v << 3)));
  endtask

  task automatic apply(input int op, input int a, input int b, input int f);
    int er, ef, em;
    @(posedge clk);
    op_sel = op[4:0]; opa = a[7:0]; opb = b[7:0]; flags_in = f[3:0];
    model(op, a, b, f, er, ef, em);
    @(negedge clk);
    n_vec++;
    if (result !== er[7:0] || flags_out !== ef[3:0] || flag_wr !== em[3:0]) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%02h b=%02h f=%h: actual r=%02h f=%h m=%h expected r=%02h f=%h m=%h (R10 R11)",
               req_of(op), op, a, b, f, result, flags_out, flag_wr, er[7:0], ef[3:0], em[3:0]);
    end
  endtask

  initial begin
    int corner[6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF};
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-state vector: all-zero inputs is a plain add of zeros (R1, R11)
    apply(0, 0, 0, 0);
    // directed boundary cases
    apply(1, 8'h7F, 8'h00, 1);  // R1 overflow via carry in
    apply(3, 8'h00, 8'h00, 0);  // R2 borrow from carry clear
    apply(9, 8'h42, 8'h42, 8);  // R5 equal compare keeps V
    apply(10, 8'hFF, 0, 0);     // R6 increment wrap
    apply(11, 8'h00, 0, 1);     // R6 decrement wrap
    apply(13, 8'h00, 0, 0);     // R7 conditional decrement borrow
    apply(12, 8'h10, 0, 0);     // R7 no carry, unchanged
    apply(14, 8'h01, 0, 1);     // R8
    apply(20, 8'h33, 8'h5A, 15); // R9
    // exhaustive op x corner x corner x flags
    for (int op = 0; op < 32; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int f = 0; f < 16; f++)
            apply(op, corner[i], corner[j], f);
    // pseudo-random sweep
    for (int k = 0; k < 3000; k++) begin
      int a, b, op, f;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr[7:0]; op = lfsr[12:8];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = lfsr[7:0]; f = lfsr[11:8];
      apply(op, a, b, f);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1..all: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule